// File: doc/BRIEF.md
# Pin Configuration Write Guard

This block holds the four per-pin configuration vectors of an 8-bit port (alternate-function select, pull-up enable, pull-down enable and digital-input enable). Software writes and reads them over a simple single-cycle register bus. A parameter mask marks some pins as guarded. These are pins whose accidental reconfiguration would cut off a debug link or a non-maskable interrupt input. By default they are bit 7 (the interrupt input) and bits 3 to 0 (the debug port). Writes to unguarded pins always land.

Guarded pins pass through two gates. A key register acts as a global lock. While the lock is open, software may change a per-pin commit vector. A guarded bit of any configuration vector changes only when the lock is open and that pin's commit bit is set. A write that is refused leaves the stored bit as it was and raises no error. Reset values of all four vectors are parameters, so debug pins can come out of reset already on their alternate function.

Top module: `pcfg_guard`

## Requirements
- R1: After reset the lock reads 1 (closed), the commit vector reads 1 for unguarded pins and 0 for guarded pins, and the four configuration vectors equal their reset parameters.
- R2: Writing the 32-bit value 0x4C4F434B to the lock register (address 4) opens the lock, and the lock register then reads 0.
- R3: Writing any other 32-bit value to the lock register closes the lock, and it then reads 1. This includes values that differ from the key in one bit.
- R4: Bits of unguarded pins in the configuration registers (address 0 alternate function, 1 pull-up, 2 pull-down, 3 digital enable; bit i is pin i) take the written value on every write.
- R5: A guarded bit of a configuration register is stored only when the lock is open and that pin's commit bit is 1. Otherwise it keeps its old value.
- R6: The commit register (address 5) changes only on a write while the lock is open. Only guarded bits are writable, and unguarded bits always read 1.
- R7: Reads return the addressed vector in bits 7..0 with zeros above. Addresses 6 and 7 read 0, and writes to them change no state.
- R8: Lock and commit state take effect for a write issued in the cycle directly after the write that set them. A write updates its register at that clock edge.
- R9: Closing the lock keeps the commit vector and all configuration values unchanged. Cycles without a write change no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| alt_sel | output | 8 | Alternate-function select per pin |
| pull_up | output | 8 | Pull-up enable per pin |
| pull_dn | output | 8 | Pull-down enable per pin |
| dig_en | output | 8 | Digital-input enable per pin |

## Verification
Free pass-through and guarded blocking happen in the same cycle. A single configuration write carries unguarded bits that must land and guarded bits whose fate depends on the lock and commit state. The bench provokes this by sweeping all 256 commit values with the lock open, and by replaying patterns with the lock closed. It writes each of the four registers with data that differs in both bit groups. Every resulting vector is judged against an arithmetic model, both at the output ports and by readback. Back-to-back unlock-then-write and relock-then-write pairs check that the gate decision uses the state registered one edge earlier.

// File: rtl/pcfg_guard_pkg.sv
package pcfg_guard_pkg;
   localparam int ADDR_W  = 3;
   localparam int DATA_W  = 32;
   localparam int NUM_CFG = 4;
   localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F434B;

   typedef enum logic [ADDR_W-1:0] {
      RA_ALT    = 3'd0,
      RA_PUP    = 3'd1,
      RA_PDN    = 3'd2,
      RA_DEN    = 3'd3,
      RA_LOCK   = 3'd4,
      RA_COMMIT = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/pcfg_key_lock.sv
module pcfg_key_lock
   import pcfg_guard_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              open_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  open_o <= 1'b0;
      else if (wr) open_o <= (wdata == UNLOCK_KEY);
   end

   AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata == UNLOCK_KEY) |=> open_o); // R2
   AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata != UNLOCK_KEY) |=> !open_o); // R3
endmodule

// File: rtl/pcfg_commit_reg.sv
module pcfg_commit_reg #(
   parameter int                NPIN  = 8,
   parameter logic [NPIN-1:0]   GUARD = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [NPIN-1:0] wdata,
   input  logic            open_i,
   output logic [NPIN-1:0] commit_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                commit_o <= ~GUARD;
      else if (wr && open_i)     commit_o <= (wdata & GUARD) | ~GUARD;
   end

   AST_COMMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !open_i) |=> $stable(commit_o)); // R6
   AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(commit_o)); // R9
endmodule

// File: rtl/pcfg_cfg_reg.sv
module pcfg_cfg_reg #(
   parameter int              NPIN  = 8,
   parameter logic [NPIN-1:0] GUARD = '1,
   parameter logic [NPIN-1:0] RST   = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [NPIN-1:0] wdata,
   input  logic            open_i,
   input  logic [NPIN-1:0] commit_i,
   output logic [NPIN-1:0] q_o
);
   for (genvar i = 0; i < NPIN; i++) begin : g_bit
      if (GUARD[i]) begin : g_guarded
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q_o[i] <= RST[i];
            else if (wr && open_i && commit_i[i]) q_o[i] <= wdata[i];
         end
      end else begin : g_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q_o[i] <= RST[i];
            else if (wr) q_o[i] <= wdata[i];
         end
      end
   end

   AST_FREE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ((q_o & ~GUARD) == ($past(wdata) & ~GUARD))); // R4
   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !open_i) |=> ((q_o & GUARD) == ($past(q_o) & GUARD))); // R5
   AST_UNCOMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ((q_o & GUARD & ~$past(commit_i)) ==
              ($past(q_o) & GUARD & ~$past(commit_i)))); // R5
endmodule

// File: rtl/pcfg_guard.sv
module pcfg_guard
   import pcfg_guard_pkg::*;
#(
   parameter int              NPIN       = 8,
   parameter logic [NPIN-1:0] GUARD_MASK = 8'h8F,
   parameter logic [NPIN-1:0] ALT_RST    = 8'h0F,
   parameter logic [NPIN-1:0] PUP_RST    = 8'h0E,
   parameter logic [NPIN-1:0] PDN_RST    = 8'h00,
   parameter logic [NPIN-1:0] DEN_RST    = 8'h8F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NPIN-1:0]   alt_sel,
   output logic [NPIN-1:0]   pull_up,
   output logic [NPIN-1:0]   pull_dn,
   output logic [NPIN-1:0]   dig_en
);
   localparam logic [NUM_CFG-1:0][NPIN-1:0] RST_TAB =
      {DEN_RST, PDN_RST, PUP_RST, ALT_RST};

   if (NPIN < 1 || NPIN > DATA_W) begin : g_bad_npin
      $error("pcfg_guard: NPIN must lie in 1..DATA_W");
   end
   if (NPIN > 8) begin : g_bad_map
      $error("pcfg_guard: register map is laid out for at most 8 pins");
   end

   logic                          lock_open;
   logic [NPIN-1:0]               commit;
   logic [NUM_CFG-1:0][NPIN-1:0]  cfg_q;

   pcfg_key_lock u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr && bus_addr == RA_LOCK),
      .wdata  (bus_wdata),
      .open_o (lock_open)
   );

   pcfg_commit_reg #(.NPIN(NPIN), .GUARD(GUARD_MASK)) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr && bus_addr == RA_COMMIT),
      .wdata    (bus_wdata[NPIN-1:0]),
      .open_i   (lock_open),
      .commit_o (commit)
   );

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
      pcfg_cfg_reg #(.NPIN(NPIN), .GUARD(GUARD_MASK), .RST(RST_TAB[g])) u_reg (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (bus_wr && bus_addr == ADDR_W'(g)),
         .wdata    (bus_wdata[NPIN-1:0]),
         .open_i   (lock_open),
         .commit_i (commit),
         .q_o      (cfg_q[g])
      );
   end

   assign alt_sel = cfg_q[0];
   assign pull_up = cfg_q[1];
   assign pull_dn = cfg_q[2];
   assign dig_en  = cfg_q[3];

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_ALT, RA_PUP, RA_PDN, RA_DEN: bus_rdata[NPIN-1:0] = cfg_q[bus_addr[1:0]];
         RA_LOCK:                        bus_rdata[0]        = ~lock_open;
         RA_COMMIT:                      bus_rdata[NPIN-1:0] = commit;
         default:                        bus_rdata           = '0;
      endcase
   end

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(cfg_q) && $stable(lock_open))); // R9
   AST_SPARE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[2:1] == 2'b11) |=>
      ($stable(cfg_q) && $stable(commit) && $stable(lock_open))); // R7
endmodule

// File: tb/pcfg_guard_tb_top.sv
`timescale 1ns/1ps
module pcfg_guard_tb_top;
   localparam logic [7:0]  G    = 8'h8F;
   localparam logic [31:0] KEY  = 32'h4C4F434B;
   localparam logic [7:0]  RALT = 8'h0F, RPUP = 8'h0E, RPDN = 8'h00, RDEN = 8'h8F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  alt_sel, pull_up, pull_dn, dig_en;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [7:0] m_cfg [4];
   logic [7:0] m_commit;
   bit         m_open;

   always #2.5 clk = ~clk;

   pcfg_guard #(.NPIN(8), .GUARD_MASK(G), .ALT_RST(RALT), .PUP_RST(RPUP),
                .PDN_RST(RPDN), .DEN_RST(RDEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_sel(alt_sel),
      .pull_up(pull_up), .pull_dn(pull_dn), .dig_en(dig_en)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_write(logic [2:0] a, logic [31:0] d);
      logic [7:0] allow;
      if (a == 3'd4) m_open = (d == KEY);
      else if (a == 3'd5) begin
         if (m_open) m_commit = (d[7:0] & G) | ~G;
      end else if (a < 3'd4) begin
         allow = ~G | (m_open ? m_commit : 8'h00);
         m_cfg[a[1:0]] = (d[7:0] & allow) | (m_cfg[a[1:0]] & ~allow);
      end
   endtask

   // one write cycle; returns at the following negedge with the strobe low
   task automatic bus_write(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   // two writes on consecutive clock edges
   task automatic bus_write2(logic [2:0] a1, logic [31:0] d1,
                             logic [2:0] a2, logic [31:0] d2);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a1; bus_wdata = d1;
      @(negedge clk);
      bus_addr = a2; bus_wdata = d2;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a1, d1);
      model_write(a2, d2);
   endtask

   task automatic read_chk(string req, logic [2:0] a, logic [31:0] exp);
      bus_addr = a;
      #0.5;
      check(req, bus_rdata, exp);
   endtask

   task automatic check_all(string req);
      check({req, " alt_sel"}, {24'h0, alt_sel}, {24'h0, m_cfg[0]});
      check({req, " pull_up"}, {24'h0, pull_up}, {24'h0, m_cfg[1]});
      check({req, " pull_dn"}, {24'h0, pull_dn}, {24'h0, m_cfg[2]});
      check({req, " dig_en"},  {24'h0, dig_en},  {24'h0, m_cfg[3]});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_cfg[0] = RALT; m_cfg[1] = RPUP; m_cfg[2] = RPDN; m_cfg[3] = RDEN;
      m_commit = ~G; m_open = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read_chk("R1 lock", 3'd4, 32'h1);
      read_chk("R1 commit", 3'd5, {24'h0, ~G});
      check_all("R1");
      for (int a = 0; a < 4; a++) read_chk("R1 readback", 3'(a), {24'h0, m_cfg[a]});

      // R4 R5 locked: only free bits move
      foreach (m_cfg[r]) begin
         bus_write(3'(r), 32'hFFFF_FFFF);
         check_all("R4 R5 locked ones");
         bus_write(3'(r), 32'h0000_00A5);
         check_all("R4 R5 locked A5");
         bus_write(3'(r), 32'h0);
         check_all("R4 R5 locked zero");
      end

      // R6 commit write while locked is dropped
      bus_write(3'd5, 32'hFF);
      read_chk("R6 locked commit", 3'd5, {24'h0, ~G});

      // R3 near-miss keys keep it closed
      for (int b = 0; b < 32; b++) begin
         bus_write(3'd4, KEY ^ (32'h1 << b));
         read_chk("R3 near key", 3'd4, 32'h1);
      end

      // R2 R8 unlock then commit on the very next edge
      bus_write2(3'd4, KEY, 3'd5, 32'hFF);
      read_chk("R2 open", 3'd4, 32'h0);
      read_chk("R8 commit after unlock", 3'd5, 32'hFF);
      read_chk("R6 model commit", 3'd5, {24'h0, m_commit});

      // R4 R5 R6 sweep of every commit value with lock open
      for (int c = 0; c < 256; c++) begin
         bus_write(3'd5, 32'(c));
         read_chk("R6 commit sweep", 3'd5, {24'h0, m_commit});
         for (int r = 0; r < 4; r++) begin
            logic [7:0] d;
            d = 8'(c * 37 + r * 91);
            bus_write(3'(r), {24'hABCDEF, d});
            bus_write(3'(r), {24'h0, ~d});
            read_chk("R5 sweep readback", 3'(r), {24'h0, m_cfg[r]});
         end
         check_all("R4 R5 sweep");
      end

      // R8 R3 relock then protected write on the next edge is refused
      bus_write(3'd5, 32'hFF);
      bus_write2(3'd4, 32'h0, 3'd0, 32'h0000_0055);
      check_all("R8 R3 relock then write");
      read_chk("R3 closed", 3'd4, 32'h1);
      read_chk("R9 commit kept", 3'd5, 32'hFF);
      bus_write(3'd1, 32'h0000_00F0);
      check_all("R9 locked with commit set");

      // R7 spare addresses
      bus_write(3'd4, KEY);
      bus_write(3'd6, 32'hFFFF_FFFF);
      bus_write(3'd7, 32'h0);
      read_chk("R7 spare 6", 3'd6, 32'h0);
      read_chk("R7 spare 7", 3'd7, 32'h0);
      read_chk("R7 lock kept", 3'd4, 32'h0);
      read_chk("R7 commit kept", 3'd5, {24'h0, m_commit});
      check_all("R7 spare write");
      bus_write(3'd2, 32'hFFFF_FF3C);
      read_chk("R7 upper zero", 3'd2, {24'h0, m_cfg[2]});

      // R9 idle cycles
      repeat (5) @(negedge clk);
      check_all("R9 idle");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule